// File: doc/BRIEF.md
# Banked GPIO Register Bank

This block is the register file that sits between a simple word-wide register bus and a wide general-purpose I/O port. The pins are grouped into banks of 32, one bank per 32-bit data word. Each register group holds an array of per-bank words placed at a fixed group offset, so bank `n` of a group lives at that offset plus `4*n`.

Software sees five groups and one configuration word:
- a read-only, synchronized view of the pin levels;
- a read/write direction group that drives the output enables;
- two write-only groups that raise or lower output latch bits without a read-modify-write;
- a read/write group of glitch-filter bypass controls, which are only held and brought out here.

Writes take effect at the clock edge that samples them. Read data is registered and appears one edge after the address.

Top module: `gpio_bank_regs`

## Requirements
- R1: While rst_ni is low and after it rises, every output enable, output latch, filter-bypass bit, read data bit and configuration bit is 0.
- R2: A read at byte address 0x004+4n returns pin_i bits [32n+31:32n], bit b belonging to pin 32n+b, taken through a two-flop synchronizer. A pin change applied before edge k is visible in read data captured at edge k+2, and not at edge k+1.
- R3: The direction group at 0x01C+4n can be read and written; a 1 in bit b drives pin_oe_o[32n+b] high (output), a 0 leaves it low (input).
- R4: Writing word W to 0x034+4n sets output latch bit 32n+b for every 1 in W and leaves the bits under a 0 unchanged; pin_o shows the latches.
- R5: Writing word W to 0x04C+4n clears output latch bit 32n+b for every 1 in W and leaves the bits under a 0 unchanged.
- R6: The filter-bypass group at 0x094+4n can be read and written; bit b drives filt_byp_o[32n+b], where 1 means bypass.
- R7: Reads of the set and clear groups, of unmapped addresses and of addresses whose two low bits are not 00 return 0. Writes to the level group or to unmapped addresses change no output and no readable register.
- R8: The configuration word at 0x000 is a 32-bit read/write register.
- R9: A write to bank n of any group leaves every other bank's latches, enables and bypass bits unchanged.
- R10: A write changes pin_o, pin_oe_o and filt_byp_o at the edge that samples we_i high. rdata_o holds the word addressed at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address of the register word |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data for the previous address |
| pin_i | input | 192 | Pin levels from the pads |
| pin_o | output | 192 | Output latch values |
| pin_oe_o | output | 192 | Output enables (1 = output) |
| filt_byp_o | output | 192 | Glitch-filter bypass controls (1 = bypass) |

## Verification
Three latencies apply. Output, enable and bypass vectors change at the edge that samples a write, so they are compared at the falling edge after it. Read data is due one edge after the address, so the monitor compares it shortly after the rising edge that followed the read request. A pin change reaches read data two edges after it is first sampled. The bench reads the level group once one edge too early, where it expects the old value, and once on time, where it expects the new one. All expected values come from the driver in issue order, so a late or early result shows up as a mismatch against the queue front.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    GRP_NONE = 3'd0,
    GRP_CFG  = 3'd1,
    GRP_LVL  = 3'd2,
    GRP_DIR  = 3'd3,
    GRP_SET  = 3'd4,
    GRP_CLR  = 3'd5,
    GRP_BYP  = 3'd6
  } grp_e;

  localparam int unsigned NUM_GRP = 5;
  // word offsets of LVL, DIR, SET, CLR, BYP (same order as grp_e from GRP_LVL)
  localparam int unsigned GRP_BASE_W [NUM_GRP] = '{32'd1, 32'd7, 32'd13, 32'd19, 32'd37};
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 192
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  a_r2_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_q == $past(s1_q));
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BANKS = 6,
  localparam int unsigned BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output grp_e              grp_o,
  output logic [BIDX_W-1:0] bank_o
);
  localparam int unsigned WA_W = ADDR_W - 2;

  logic [WA_W-1:0] wa;
  assign wa = addr_i[ADDR_W-1:2];

  always_comb begin
    grp_o  = GRP_NONE;
    bank_o = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (wa == '0) grp_o = GRP_CFG;
      for (int g = 0; g < NUM_GRP; g++) begin
        if (32'(wa) >= GRP_BASE_W[g] && 32'(wa) < GRP_BASE_W[g] + NUM_BANKS) begin
          grp_o  = grp_e'(3'(g + 2));
          bank_o = BIDX_W'(32'(wa) - GRP_BASE_W[g]);
        end
      end
    end
  end
endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice #(
  parameter int unsigned BANK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_dir_i,
  input  logic              wr_set_i,
  input  logic              wr_clr_i,
  input  logic              wr_byp_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] dir_o,
  output logic [BANK_W-1:0] out_o,
  output logic [BANK_W-1:0] byp_o
);
  logic [BANK_W-1:0] dir_q, out_q, byp_q;
  logic [BANK_W-1:0] set_m, clr_m;

  assign set_m = wr_set_i ? wdata_i : '0;
  assign clr_m = wr_clr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
      byp_q <= '0;
    end else begin
      if (wr_dir_i) dir_q <= wdata_i;
      if (wr_byp_i) byp_q <= wdata_i;
      out_q <= (out_q | set_m) & ~clr_m;
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
  assign byp_o = byp_q;

  a_r4_set_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set_i |=> out_q == ($past(out_q) | $past(wdata_i)));

  a_r5_clr_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_i |=> out_q == ($past(out_q) & ~$past(wdata_i)));

  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_dir_i || wr_set_i || wr_clr_i || wr_byp_i)
      |=> ($stable(out_q) && $stable(dir_q) && $stable(byp_q)));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BANKS = 6,
  parameter int unsigned BANK_W    = 32,
  localparam int unsigned N_PINS   = NUM_BANKS * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic [N_PINS-1:0] filt_byp_o
);
  localparam int unsigned BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  grp_e              grp;
  logic [BIDX_W-1:0] bank;
  logic [N_PINS-1:0] pin_s;
  logic [BANK_W-1:0] cfg_q, rd_mux, rdata_q;
  logic [BANK_W-1:0] dir_w [NUM_BANKS];
  logic [BANK_W-1:0] out_w [NUM_BANKS];
  logic [BANK_W-1:0] byp_w [NUM_BANKS];
  logic [NUM_BANKS-1:0] wr_any;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr_i (addr_i),
    .grp_o  (grp),
    .bank_o (bank)
  );

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = we_i && (32'(bank) == b);
    assign wr_any[b] = hit && (grp inside {GRP_DIR, GRP_SET, GRP_CLR, GRP_BYP});

    gpio_bank_slice #(.BANK_W(BANK_W)) u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_dir_i (hit && grp == GRP_DIR),
      .wr_set_i (hit && grp == GRP_SET),
      .wr_clr_i (hit && grp == GRP_CLR),
      .wr_byp_i (hit && grp == GRP_BYP),
      .wdata_i  (wdata_i),
      .dir_o    (dir_w[b]),
      .out_o    (out_w[b]),
      .byp_o    (byp_w[b])
    );

    assign pin_oe_o[b*BANK_W +: BANK_W]   = dir_w[b];
    assign pin_o[b*BANK_W +: BANK_W]      = out_w[b];
    assign filt_byp_o[b*BANK_W +: BANK_W] = byp_w[b];
  end

  always_comb begin
    rd_mux = '0;
    unique case (grp)
      GRP_CFG: rd_mux = cfg_q;
      GRP_LVL: rd_mux = pin_s[32'(bank)*BANK_W +: BANK_W];
      GRP_DIR: rd_mux = dir_w[bank];
      GRP_BYP: rd_mux = byp_w[bank];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i && grp == GRP_CFG) cfg_q <= wdata_i;
      rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;

  a_r7_wo_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp inside {GRP_SET, GRP_CLR, GRP_NONE}) |=> rdata_o == '0);

  a_r9_one_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_any));

  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && grp == GRP_CFG) |=> $stable(cfg_q));

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_o == '0 && pin_oe_o == '0 && filt_byp_o == '0 && rdata_o == '0));
endmodule

// File: tb/sim_gpio_bank_regs.sv
`timescale 1ns/1ps
module sim_gpio_bank_regs;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [11:0]   addr_i = '0;
  logic          we_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [191:0]  pin_i = '0;
  logic [191:0]  pin_o, pin_oe_o, filt_byp_o;

  logic          issue = 1'b0;
  logic [31:0]   exp_q [$];
  string         tag_q [$];
  int            n_chk = 0;
  int            n_fail = 0;
  logic [191:0]  e_out = '0, e_oe = '0, e_byp = '0;

  always #2.5 clk_i = ~clk_i;

  gpio_bank_regs u0 (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .pin_i, .pin_o, .pin_oe_o, .filt_byp_o
  );

  task automatic chk(input logic [191:0] act, input logic [191:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    we_i = 1'b0; issue = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1; issue = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0; wdata_i = '0; issue = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic set_pins(input logic [191:0] v);
    @(negedge clk_i);
    pin_i = v; we_i = 1'b0; issue = 1'b0;
  endtask

  task automatic chk_pins(input string tag);
    idle();
    chk(pin_o, e_out, {tag, " pin_o"});
    chk(pin_oe_o, e_oe, {tag, " pin_oe_o"});
    chk(filt_byp_o, e_byp, {tag, " filt_byp_o"});
  endtask

  // monitor: read data is due just after the edge that sampled the request
  initial forever begin
    @(posedge clk_i);
    if (issue) begin
      #1;
      if (exp_q.size() == 0) chk(1, 0, "scoreboard underflow");
      else chk(192'(rdata_o), 192'(exp_q.pop_front()), tag_q.pop_front());
    end
  end

  initial begin
    #100000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 in reset
    chk(pin_o, '0, "R1 pin_o in reset");
    chk(pin_oe_o, '0, "R1 pin_oe_o in reset");
    chk(filt_byp_o, '0, "R1 filt_byp_o in reset");
    chk(192'(rdata_o), '0, "R1 rdata in reset");
    rst_ni = 1'b1;
    rd(12'h01C, 32'h0, "R1 dir bank0 after reset");
    rd(12'h000, 32'h0, "R1 cfg after reset");

    // R8 config word
    wr(12'h000, 32'hA5A5_0F0F);
    rd(12'h000, 32'hA5A5_0F0F, "R8 cfg readback");

    // R3 direction bank2, R10 same-edge effect
    wr(12'h024, 32'h0000_FFFF);
    e_oe[95:64] = 32'h0000_FFFF;
    chk_pins("R3 R10 dir bank2");
    rd(12'h024, 32'h0000_FFFF, "R3 dir bank2 readback");

    // R4 set bank1
    wr(12'h038, 32'hF0F0_0001);
    e_out[63:32] = 32'hF0F0_0001;
    chk_pins("R4 set bank1");
    wr(12'h038, 32'h0000_0002);
    e_out[63:32] = 32'hF0F0_0003;
    chk_pins("R4 set keeps zeros");
    rd(12'h038, 32'h0, "R7 set group reads zero");

    // R5 clear bank1
    wr(12'h050, 32'hF000_0001);
    e_out[63:32] = 32'h00F0_0002;
    chk_pins("R5 clr bank1");
    rd(12'h050, 32'h0, "R7 clr group reads zero");

    // R6 bypass bank5 (last bank)
    wr(12'h0A8, 32'h8000_0001);
    e_byp[191:160] = 32'h8000_0001;
    chk_pins("R6 byp bank5");
    rd(12'h0A8, 32'h8000_0001, "R6 byp bank5 readback");

    // R9 write to bank0 direction leaves bank2
    wr(12'h01C, 32'h0000_0010);
    e_oe[31:0] = 32'h0000_0010;
    chk_pins("R9 other banks hold");
    rd(12'h024, 32'h0000_FFFF, "R9 dir bank2 unchanged");

    // R2 level with synchronizer latency
    set_pins({32'hDEAD_BEEF, 128'h0, 32'h1234_5678});
    rd(12'h004, 32'h0, "R2 level one edge early");
    rd(12'h004, 32'h1234_5678, "R2 level bank0");
    rd(12'h018, 32'hDEAD_BEEF, "R2 level bank5");

    // R7 ignored writes and unmapped reads
    wr(12'h004, 32'hFFFF_FFFF);
    chk_pins("R7 level write ignored");
    rd(12'h004, 32'h1234_5678, "R7 level unchanged");
    wr(12'h064, 32'hFFFF_FFFF);
    chk_pins("R7 unmapped write ignored");
    rd(12'h064, 32'h0, "R7 unmapped gap reads zero");
    rd(12'h0AC, 32'h0, "R7 past bypass end reads zero");
    rd(12'h026, 32'h0, "R7 unaligned reads zero");
    wr(12'h025, 32'h0);
    chk_pins("R7 unaligned write ignored");
    rd(12'h000, 32'hA5A5_0F0F, "R8 cfg unchanged");

    idle();
    idle();
    idle();
    if (exp_q.size() != 0) chk(192'(exp_q.size()), 0, "scoreboard leftover");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule